// File: doc/BRIEF.md
# LCD Frame Clock Prescaler

This block produces the timing enable for a multiplexed LCD controller. It counts ticks from one of two sources. The first is the system clock itself. The second is a slow external clock, such as a 32 kHz crystal, which is sampled into the system clock domain. A 12-bit counter divides the chosen tick stream by one of eight power-of-two ratios. A fine divider then divides the result again by 1 to 8. The output is a pulse one system clock cycle wide, and the LCD waveform sequencer uses it as its step enable.

Everything runs on the system clock and no clock is generated. The external input only needs to be slower than half the system clock rate. The block guards its own ratio settings: a change to either setting restarts the division from zero. A change of source keeps the counters cleared until the new source delivers its first tick.

Top module: `lcd_frame_prescaler`

## Requirements
- R1: With `src_sel` = 0, every system clock cycle counts as one source tick.
- R2: While `rst_sys_n` is low, `lcd_tick` is 0 and the source is the system clock. After reset is released with both ratio codes at 0, the first `lcd_tick` pulse follows the 16th rising edge, counting the first edge with reset high as edge 1.
- R3: `coarse_sel` codes 0, 1, 2, 3, 4, 5, 6 and 7 divide the source ticks by 16, 64, 128, 256, 512, 1024, 2048 and 4096.
- R4: `fine_sel` code N divides the coarse rate by N+1. Successive `lcd_tick` pulses are therefore spaced coarse ratio × (N+1) source ticks apart.
- R5: Each `lcd_tick` pulse lasts exactly one system clock cycle.
- R6: A change of `coarse_sel` or `fine_sel` clears both dividers. Call the edge that captures the new value edge 1. The first pulse under the new setting then follows edge M+1, where M is the new full period.
- R7: With `src_sel` = 1, each rising edge of `ext_clk` counts as one source tick after synchronisation. Pulses are spaced M external periods apart, with a jitter of at most one system clock cycle.
- R8: While a source change is pending, the counters stay cleared and `lcd_tick` stays 0. If the external clock is selected but does not toggle, no pulse appears. After a return to the system clock, call the capturing edge edge 1; the first pulse follows edge M+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; all logic is clocked by it |
| rst_sys_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | Slow asynchronous external clock, under half the system rate |
| src_sel | input | 1 | Source select: 0 system clock, 1 external clock |
| coarse_sel | input | 3 | Coarse ratio code (0..7 → 16..4096) |
| fine_sel | input | 3 | Fine ratio code N, divide by N+1 |
| lcd_tick | output | 1 | One-cycle LCD timing enable |

## Verification
The hardest situation to reach is a source switch. During the switch, the hold window must swallow every tick until the newly selected clock has actually produced an edge. The stimulus selects the external source while that clock is parked and checks that no pulse appears. It then starts the clock and measures pulse spacing in time. Finally it switches back to the system clock and counts the exact edge of the first pulse. Ratio changes are made at random points inside a running period. This shows that the restart clears a partly advanced count instead of letting it finish.

// File: rtl/lcd_presc_pkg.sv
// Package: shared constants and the coarse tap mapping of the prescaler.
// Assumes: coarse codes are 3 bits wide; the largest tap needs a 12-bit counter.
package lcd_presc_pkg;

    localparam int unsigned COARSE_CODES = 8;
    localparam int unsigned MIN_CNT_W    = 12;

    // Maps a coarse code to log2 of its division ratio (16, 64, then 128..4096).
    function automatic int unsigned coarse_log2(input int unsigned code);
        if (code == 0) return 4;
        if (code == 1) return 6;
        return code + 5;
    endfunction

endpackage

// File: rtl/lcd_src_select.sv
// Module: chooses the tick source and manages source switching.
// The external clock passes through a synchroniser, and each of its rising
// edges becomes one tick. On a change of src_sel, hold stays asserted until
// the new source is running: one cycle for the system clock, the first
// synchronised edge for the external clock.
// Assumes: ext_clk is slower than half of clk_sys.
module lcd_src_select #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_sys,
    input  logic rst_sys_n,
    input  logic ext_clk,
    input  logic src_sel,
    output logic src_tick,
    output logic hold,
    output logic switching
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_r;
    logic                   ext_prev;
    logic                   ext_rise;
    logic                   src_q;
    logic                   hold_r;

    // Synchroniser chain for the external clock, plus the previous sampled level.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n) begin
            sync_r   <= '0;
            ext_prev <= 1'b0;
        end else begin
            sync_r   <= {sync_r[SYNC_STAGES-2:0], ext_clk};
            ext_prev <= sync_r[MSB];
        end
    end

    assign ext_rise = sync_r[MSB] & ~ext_prev;

    // Registered source selection; the system clock is the reset default.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n) src_q <= 1'b0;
        else            src_q <= src_sel;
    end

    assign switching = (src_sel != src_q);

    // Hold window: set on a switch, released once the new source is running.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n)                            hold_r <= 1'b0;
        else if (switching)                        hold_r <= 1'b1;
        else if (hold_r && (!src_q || ext_rise))   hold_r <= 1'b0;
    end

    assign hold     = hold_r;
    assign src_tick = !hold_r && !switching && (src_q ? ext_rise : 1'b1);

    // Synchronised external edges are never back to back (R7).
    assert_ext_tick_spacing_R7: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (src_q && src_tick) |=> !src_tick);

endmodule

// File: rtl/lcd_cfg_watch.sv
// Module: registers the ratio settings and flags any change to them.
// cfg_clr is asserted in the cycle where an input differs from its stored
// copy. At the same edge the dividers clear and the copy takes the new value.
// Assumes: settings are static relative to clk_sys (quasi-static control bits).
module lcd_cfg_watch #(
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned FINE_W = 3
) (
    input  logic              clk_sys,
    input  logic              rst_sys_n,
    input  logic [SEL_W-1:0]  coarse_sel,
    input  logic [FINE_W-1:0] fine_sel,
    output logic [SEL_W-1:0]  coarse_q,
    output logic [FINE_W-1:0] fine_q,
    output logic              cfg_clr
);
    // Stored copies of the active ratio settings.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else begin
            coarse_q <= coarse_sel;
            fine_q   <= fine_sel;
        end
    end

    assign cfg_clr = (coarse_sel != coarse_q) || (fine_sel != fine_q);

endmodule

// File: rtl/lcd_coarse_div.sv
// Module: coarse divider. A free-running counter advances on each source
// tick, and one tap per coarse code detects that the tap's low bits are all
// ones. The selected tap, qualified by the tick, gives the coarse tick.
// Assumes: CNT_W covers the largest tap of the package mapping.
module lcd_coarse_div
    import lcd_presc_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_sys,
    input  logic             rst_sys_n,
    input  logic             clr,
    input  logic             src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             coarse_tick
);
    localparam int unsigned N_TAPS = 1 << SEL_W;

    logic [CNT_W-1:0]  cnt;
    logic [N_TAPS-1:0] tap_hit;
    logic [CNT_W-1:0]  tap_mask [N_TAPS];

    // Tap detectors, one for each coarse code.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned TB = coarse_log2(g);
        assign tap_hit[g]  = &cnt[TB-1:0];
        assign tap_mask[g] = CNT_W'((64'd1 << TB) - 64'd1);
    end

    // Source-tick counter, cleared on any restart.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n || clr) cnt <= '0;
        else if (src_tick)     cnt <= cnt + 1'b1;
    end

    assign coarse_tick = src_tick && tap_hit[sel];

    // After a coarse tick the selected low bits restart at zero (R3).
    assert_tap_wraps_R3: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (coarse_tick && !clr) |=> ((cnt & tap_mask[$past(sel)]) == '0));

endmodule

// File: rtl/lcd_fine_div.sv
// Module: fine divider. It counts coarse ticks from 0 to the fine code and
// emits a registered one-cycle pulse on the last of them, giving division by
// code+1.
// Assumes: coarse ticks are never on consecutive cycles (coarse ratio >= 16).
module lcd_fine_div #(
    parameter int unsigned FINE_W = 3
) (
    input  logic              clk_sys,
    input  logic              rst_sys_n,
    input  logic              clr,
    input  logic              coarse_tick,
    input  logic [FINE_W-1:0] fine_q,
    output logic              lcd_tick
);
    logic [FINE_W-1:0] fine_cnt;

    // Fine count and output pulse register.
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n || clr) begin
            fine_cnt <= '0;
            lcd_tick <= 1'b0;
        end else if (coarse_tick) begin
            if (fine_cnt == fine_q) begin
                fine_cnt <= '0;
                lcd_tick <= 1'b1;
            end else begin
                fine_cnt <= fine_cnt + 1'b1;
                lcd_tick <= 1'b0;
            end
        end else begin
            lcd_tick <= 1'b0;
        end
    end

    // The fine count never passes the active code (R4).
    assert_fine_in_range_R4: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        fine_cnt <= fine_q);

endmodule

// File: rtl/lcd_frame_prescaler.sv
// Module: top of the LCD frame clock prescaler. It connects source
// selection, the settings watcher, and the coarse and fine dividers. Every
// restart cause (a ratio change, a pending switch, the hold window) clears
// both dividers together.
// Assumes: all control inputs are quasi-static in the clk_sys domain.
module lcd_frame_prescaler
    import lcd_presc_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned FINE_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_sys,
    input  logic              rst_sys_n,
    input  logic              ext_clk,
    input  logic              src_sel,
    input  logic [SEL_W-1:0]  coarse_sel,
    input  logic [FINE_W-1:0] fine_sel,
    output logic              lcd_tick
);
    logic              src_tick;
    logic              hold;
    logic              switching;
    logic              cfg_clr;
    logic              clr_all;
    logic              coarse_tick;
    logic [SEL_W-1:0]  coarse_q;
    logic [FINE_W-1:0] fine_q;

    lcd_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk_sys   (clk_sys),
        .rst_sys_n (rst_sys_n),
        .ext_clk   (ext_clk),
        .src_sel   (src_sel),
        .src_tick  (src_tick),
        .hold      (hold),
        .switching (switching)
    );

    lcd_cfg_watch #(.SEL_W(SEL_W), .FINE_W(FINE_W)) u_cfg (
        .clk_sys    (clk_sys),
        .rst_sys_n  (rst_sys_n),
        .coarse_sel (coarse_sel),
        .fine_sel   (fine_sel),
        .coarse_q   (coarse_q),
        .fine_q     (fine_q),
        .cfg_clr    (cfg_clr)
    );

    // Single restart condition shared by both dividers.
    assign clr_all = cfg_clr || hold || switching;

    lcd_coarse_div #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_coarse (
        .clk_sys     (clk_sys),
        .rst_sys_n   (rst_sys_n),
        .clr         (clr_all),
        .src_tick    (src_tick),
        .sel         (coarse_q),
        .coarse_tick (coarse_tick)
    );

    lcd_fine_div #(.FINE_W(FINE_W)) u_fine (
        .clk_sys     (clk_sys),
        .rst_sys_n   (rst_sys_n),
        .clr         (clr_all),
        .coarse_tick (coarse_tick),
        .fine_q      (fine_q),
        .lcd_tick    (lcd_tick)
    );

    // Enable pulses are exactly one cycle wide (R5).
    assert_single_pulse_R5: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        lcd_tick |=> !lcd_tick);

    // No pulse while a source change is pending or being held (R8).
    assert_quiet_in_hold_R8: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (hold || switching) |=> !lcd_tick);

    // A ratio change silences the output on the next cycle (R6).
    assert_restart_quiet_R6: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        cfg_clr |=> !lcd_tick);

endmodule

// File: tb/lcd_frame_prescaler_tb.sv
`timescale 1ns/1ps
module lcd_frame_prescaler_tb;

    logic       clk_sys = 1'b0;
    logic       rst_sys_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ext_run = 1'b0;
    logic       src_sel = 1'b0;
    logic [2:0] coarse_sel = 3'd0;
    logic [2:0] fine_sel = 3'd0;
    logic       lcd_tick;

    int checks = 0;
    int errors = 0;

    always #2.5 clk_sys = ~clk_sys;
    always #19 if (ext_run) ext_clk = ~ext_clk;

    lcd_frame_prescaler u_dut (
        .clk_sys    (clk_sys),
        .rst_sys_n  (rst_sys_n),
        .ext_clk    (ext_clk),
        .src_sel    (src_sel),
        .coarse_sel (coarse_sel),
        .fine_sel   (fine_sel),
        .lcd_tick   (lcd_tick)
    );

    function automatic int exp_period(input int c, input int f);
        int base;
        case (c)
            0: base = 16;    1: base = 64;    2: base = 128;   3: base = 256;
            4: base = 512;   5: base = 1024;  6: base = 2048;  default: base = 4096;
        endcase
        return base * (f + 1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising edges until lcd_tick is seen at a falling edge; -1 on timeout.
    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        forever begin
            @(posedge clk_sys);
            n++;
            @(negedge clk_sys);
            if (lcd_tick) return;
            if (n >= limit) begin n = -1; return; end
        end
    endtask

    // Applies a new setting and checks the first pulse, the spacing and the width.
    task automatic run_cfg(input int c, input int f);
        int n;
        int m;
        m = exp_period(c, f);
        @(negedge clk_sys);
        coarse_sel = 3'(c);
        fine_sel   = 3'(f);
        wait_pulse(m + 10, n);
        check(n == m + 1, "R6 first pulse after setting change", n, m + 1);
        @(posedge clk_sys);
        @(negedge clk_sys);
        check(lcd_tick == 1'b0, "R5 pulse width", lcd_tick, 0);
        wait_pulse(m + 10, n);
        check(n == m - 1, "R3/R4 spacing R1", n + 1, m);
    endtask

    initial begin
        int n;
        int c;
        int f;
        realtime t1;
        realtime t2;
        realtime d;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk_sys);
        check(lcd_tick == 1'b0, "R2 output low in reset", lcd_tick, 0);
        rst_sys_n = 1'b1;
        wait_pulse(100, n);
        check(n == 16, "R2 first pulse after reset", n, 16);
        wait_pulse(100, n);
        check(n == 16, "R1 R3 code 0 spacing", n, 16);

        // Directed corners: largest ratio, largest fine code, mid values.
        run_cfg(7, 0);
        run_cfg(0, 7);
        run_cfg(3, 2);
        run_cfg(1, 0);
        run_cfg(2, 1);

        // Random settings, each forced to differ from the current one.
        for (int i = 0; i < 10; i++) begin
            c = int'($urandom % 5);
            f = int'($urandom % 8);
            if (c == int'(coarse_sel) && f == int'(fine_sel)) f = (f + 1) % 8;
            // Change lands at a random point inside a running period.
            repeat (int'($urandom % 40)) @(negedge clk_sys);
            run_cfg(c, f);
        end

        // External source selected but stopped: no pulse may appear (R8).
        @(negedge clk_sys);
        coarse_sel = 3'd0;
        fine_sel   = 3'd0;
        src_sel    = 1'b1;
        wait_pulse(400, n);
        check(n == -1, "R8 no pulse with stopped external clock", n, -1);

        // Running external clock: spacing measured in time (R7).
        ext_run = 1'b1;
        wait_pulse(2000, n);
        t1 = $realtime;
        wait_pulse(2000, n);
        t2 = $realtime;
        d = t2 - t1 - 16.0 * 38.0;
        check(n > 0 && d <= 5.0 && d >= -5.0, "R7 external spacing 16", longint'(t2 - t1), 608);
        @(negedge clk_sys);
        fine_sel = 3'd2;
        wait_pulse(4000, n);
        t1 = $realtime;
        wait_pulse(4000, n);
        t2 = $realtime;
        d = t2 - t1 - 48.0 * 38.0;
        check(n > 0 && d <= 5.0 && d >= -5.0, "R7 R4 external spacing 48", longint'(t2 - t1), 1824);

        // Back to the system clock: first pulse after M+2 edges (R8).
        @(negedge clk_sys);
        fine_sel = 3'd0;
        wait_pulse(2000, n);
        @(negedge clk_sys);
        src_sel = 1'b0;
        wait_pulse(100, n);
        check(n == 18, "R8 first pulse after return to system clock", n, 18);
        wait_pulse(100, n);
        check(n == 16, "R1 spacing after return", n, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(750000.0);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule